// File: doc/BRIEF.md
# Per-Pin Pad Source Multiplexer

This block sits between the logic of one 8-pin port and its pads. For every pin it decides which source drives the pad and how that source drives it. The source can be general-purpose data, either of two alternate peripheral outputs, or nothing. The drive style can be push-pull or open collector. The block also gates the raw pad values on their way to on-chip peripheral inputs. A per-pin analog flag takes the pin away from all digital use. A single port-wide flag hands the whole port to an external memory bus.

Configuration comes through a small write-only port with five addresses. The pad outputs are combinational functions of the configuration registers and the live inputs. Pads are modelled as separate out and output-enable signals, with no tristate.

Top module: `pinmux_port`

## Requirements
- R1: After reset, every configuration register is zero. So `pad_oe_o`, `periph_in_o` and `mem_in_o` are all zero, whatever the inputs are.
- R2: A pin whose 2-bit selector is 00 never enables its pad driver, and drives `pad_out_o` low.
- R3: With selector 01 and type 0 (push-pull), the pad carries `gpio_out_i` and its enable follows `gpio_dir_i`.
- R4: Selector 10 routes `alt2_out_i`/`alt2_oe_i` to the pad, and selector 11 routes `alt3_out_i`/`alt3_oe_i`.
- R5: With type 1 (open collector), `pad_out_o` is 0. `pad_oe_o` is 1 only when the selected enable is 1 and the selected data is 0.
- R6: `periph_in_o` of a pin equals `pad_in_i` when its connect bit is 1, and is 0 when the connect bit is 0.
- R7: While a pin's analog bit is 1, its `pad_oe_o`, `pad_out_o`, `periph_in_o` and `mem_in_o` are 0, whatever the other settings are.
- R8: Setting a pin's analog bit clears that pin's selector and connect bit. While the analog bit stays set, writes to those fields are forced to 0 for that pin.
- R9: While the memory-handoff bit is 1, each non-analog pin drives `mem_out_i` with enable `mem_oe_i` as push-pull, ignoring selector and type. `mem_in_o` then equals `pad_in_i`, and `periph_in_o` is 0. While the bit is 0, `mem_in_o` is 0.
- R10: Register map, written when `cfg_we_i` is 1:
  - address 0: selectors, with pin i in data bits [2i+1:2i];
  - address 1: type, with pin i in bit i;
  - address 2: connect, with pin i in bit i;
  - address 3: analog, with pin i in bit i;
  - address 4: memory handoff, in bit 0.
  
  Writes to addresses 5 to 7, and any cycle with `cfg_we_i` at 0, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 16 | Configuration write data |
| gpio_out_i | input | 8 | General-purpose output data |
| gpio_dir_i | input | 8 | General-purpose direction, 1 = output |
| alt2_out_i | input | 8 | Alternate peripheral 2 data |
| alt2_oe_i | input | 8 | Alternate peripheral 2 enable |
| alt3_out_i | input | 8 | Alternate peripheral 3 data |
| alt3_oe_i | input | 8 | Alternate peripheral 3 enable |
| mem_out_i | input | 8 | External memory bus data |
| mem_oe_i | input | 8 | External memory bus enable |
| pad_in_i | input | 8 | Raw pad input values |
| pad_out_o | output | 8 | Pad drive value |
| pad_oe_o | output | 8 | Pad output enable |
| periph_in_o | output | 8 | Gated peripheral inputs |
| mem_in_o | output | 8 | Pad values toward the memory bus |

## Verification
Every register bit reaches the pads combinationally. A wrong selector, type, connect or analog bit therefore shows at `pad_out_o`, `pad_oe_o` or `periph_in_o` in the cycle after the write that set it, provided the live inputs differ between the candidate sources. The stimulus keeps the sources distinct so that a misrouted pin cannot hide. A failure to clear on an analog write stays invisible while the analog override holds. It only appears once the analog bit is cleared again, so the bench always follows an analog phase with a check taken after that clear.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  typedef enum logic [1:0] {
    SEL_IN   = 2'b00,
    SEL_GPIO = 2'b01,
    SEL_ALT2 = 2'b10,
    SEL_ALT3 = 2'b11
  } out_sel_e;

  localparam int unsigned CFG_AW = 3;

  typedef enum logic [CFG_AW-1:0] {
    A_SEL  = 3'd0,
    A_TYPE = 3'd1,
    A_CONN = 3'd2,
    A_ANA  = 3'd3,
    A_MEM  = 3'd4
  } cfg_addr_e;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned WD_W = 2 * NUM_PINS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [CFG_AW-1:0]         addr_i,
  input  logic [WD_W-1:0]           wdata_i,
  output logic [NUM_PINS-1:0][1:0]  sel_o,
  output logic [NUM_PINS-1:0]       oc_o,
  output logic [NUM_PINS-1:0]       conn_o,
  output logic [NUM_PINS-1:0]       ana_o,
  output logic                      mem_o
);
  logic [NUM_PINS-1:0][1:0] sel_q;
  logic [NUM_PINS-1:0]      oc_q, conn_q, ana_q;
  logic                     mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      oc_q   <= '0;
      conn_q <= '0;
      ana_q  <= '0;
      mem_q  <= 1'b0;
    end else if (we_i) begin
      case (cfg_addr_e'(addr_i))
        A_SEL:
          for (int i = 0; i < NUM_PINS; i++)
            sel_q[i] <= ana_q[i] ? 2'b00 : wdata_i[2*i +: 2];
        A_TYPE: oc_q   <= wdata_i[NUM_PINS-1:0];
        A_CONN: conn_q <= wdata_i[NUM_PINS-1:0] & ~ana_q;
        A_ANA: begin
          ana_q  <= wdata_i[NUM_PINS-1:0];
          conn_q <= conn_q & ~wdata_i[NUM_PINS-1:0];
          for (int i = 0; i < NUM_PINS; i++)
            if (wdata_i[i]) sel_q[i] <= 2'b00;
        end
        A_MEM:  mem_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign sel_o  = sel_q;
  assign oc_o   = oc_q;
  assign conn_o = conn_q;
  assign ana_o  = ana_q;
  assign mem_o  = mem_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    p_analog_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ana_q[g] |-> (sel_q[g] == 2'b00 && !conn_q[g]))
      else $error("R8: analog pin %0d holds select or connect", g);
  end

  p_ignored_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(sel_q) && $stable(oc_q) && $stable(conn_q) && $stable(ana_q) && $stable(mem_q)))
    else $error("R10: state changed without write");
endmodule

// File: rtl/pinmux_pin.sv
module pinmux_pin
  import pinmux_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       oc_i,
  input  logic       conn_i,
  input  logic       ana_i,
  input  logic       mem_i,
  input  logic       gpio_out_i,
  input  logic       gpio_dir_i,
  input  logic       alt2_out_i,
  input  logic       alt2_oe_i,
  input  logic       alt3_out_i,
  input  logic       alt3_oe_i,
  input  logic       mem_out_i,
  input  logic       mem_oe_i,
  input  logic       pad_in_i,
  output logic       pad_out_o,
  output logic       pad_oe_o,
  output logic       periph_in_o,
  output logic       mem_in_o
);
  logic data, en;

  always_comb begin
    unique case (out_sel_e'(sel_i))
      SEL_GPIO: begin data = gpio_out_i; en = gpio_dir_i; end
      SEL_ALT2: begin data = alt2_out_i; en = alt2_oe_i;  end
      SEL_ALT3: begin data = alt3_out_i; en = alt3_oe_i;  end
      default:  begin data = 1'b0;       en = 1'b0;       end
    endcase
    if (mem_i) begin
      data = mem_out_i;
      en   = mem_oe_i;
    end
    if (oc_i && !mem_i) begin
      pad_out_o = 1'b0;
      pad_oe_o  = en & ~data;
    end else begin
      pad_out_o = data;
      pad_oe_o  = en;
    end
    if (ana_i) begin
      pad_out_o = 1'b0;
      pad_oe_o  = 1'b0;
    end
  end

  assign periph_in_o = pad_in_i & conn_i & ~ana_i & ~mem_i;
  assign mem_in_o    = pad_in_i & mem_i & ~ana_i;
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned WD_W = 2 * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [WD_W-1:0]     cfg_wdata_i,
  input  logic [NUM_PINS-1:0] gpio_out_i,
  input  logic [NUM_PINS-1:0] gpio_dir_i,
  input  logic [NUM_PINS-1:0] alt2_out_i,
  input  logic [NUM_PINS-1:0] alt2_oe_i,
  input  logic [NUM_PINS-1:0] alt3_out_i,
  input  logic [NUM_PINS-1:0] alt3_oe_i,
  input  logic [NUM_PINS-1:0] mem_out_i,
  input  logic [NUM_PINS-1:0] mem_oe_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] periph_in_o,
  output logic [NUM_PINS-1:0] mem_in_o
);
  logic [NUM_PINS-1:0][1:0] sel;
  logic [NUM_PINS-1:0]      oc, conn, ana;
  logic                     mem;

  pinmux_regs #(.NUM_PINS(NUM_PINS)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .sel_o   (sel),
    .oc_o    (oc),
    .conn_o  (conn),
    .ana_o   (ana),
    .mem_o   (mem)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pinmux_pin i_pin (
      .sel_i       (sel[g]),
      .oc_i        (oc[g]),
      .conn_i      (conn[g]),
      .ana_i       (ana[g]),
      .mem_i       (mem),
      .gpio_out_i  (gpio_out_i[g]),
      .gpio_dir_i  (gpio_dir_i[g]),
      .alt2_out_i  (alt2_out_i[g]),
      .alt2_oe_i   (alt2_oe_i[g]),
      .alt3_out_i  (alt3_out_i[g]),
      .alt3_oe_i   (alt3_oe_i[g]),
      .mem_out_i   (mem_out_i[g]),
      .mem_oe_i    (mem_oe_i[g]),
      .pad_in_i    (pad_in_i[g]),
      .pad_out_o   (pad_out_o[g]),
      .pad_oe_o    (pad_oe_o[g]),
      .periph_in_o (periph_in_o[g]),
      .mem_in_o    (mem_in_o[g])
    );

    p_unsel_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel[g] == 2'b00 && !mem) |-> !pad_oe_o[g])
      else $error("R2: pin %0d drives in input mode", g);
    p_oc_no_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oc[g] && !mem) |-> !pad_out_o[g])
      else $error("R5: open-collector pin %0d drives high", g);
    p_unconn_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !conn[g] |-> !periph_in_o[g])
      else $error("R6: unconnected pin %0d passes input", g);
    p_analog_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ana[g] |-> !(pad_oe_o[g] || periph_in_o[g] || mem_in_o[g]))
      else $error("R7: analog pin %0d active", g);
  end

  p_mem_in_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem |-> (mem_in_o == '0))
    else $error("R9: memory input leaks");
endmodule

// File: tb/test_pinmux_port.sv
module test_pinmux_port;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [2*N-1:0] cfg_wdata = '0;
  logic [N-1:0] gpio_out = '0, gpio_dir = '0, alt2_out = '0, alt2_oe = '0;
  logic [N-1:0] alt3_out = '0, alt3_oe = '0, mem_out = '0, mem_oe = '0, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, periph_in, mem_in;

  int checks = 0, errors = 0;

  logic [N-1:0][1:0] m_sel = '0;
  logic [N-1:0] m_oc = '0, m_conn = '0, m_ana = '0;
  logic m_mem = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_port i_pinmux_port (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .gpio_out_i(gpio_out), .gpio_dir_i(gpio_dir),
    .alt2_out_i(alt2_out), .alt2_oe_i(alt2_oe), .alt3_out_i(alt3_out),
    .alt3_oe_i(alt3_oe), .mem_out_i(mem_out), .mem_oe_i(mem_oe), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .periph_in_o(periph_in), .mem_in_o(mem_in)
  );

  function automatic logic [4*N-1:0] expect_all();
    logic [N-1:0] eo, ee, ep, em;
    for (int i = 0; i < N; i++) begin
      logic d, e;
      case (m_sel[i])
        2'b01:   begin d = gpio_out[i]; e = gpio_dir[i]; end
        2'b10:   begin d = alt2_out[i]; e = alt2_oe[i];  end
        2'b11:   begin d = alt3_out[i]; e = alt3_oe[i];  end
        default: begin d = 1'b0;        e = 1'b0;        end
      endcase
      if (m_mem) begin
        eo[i] = mem_out[i]; ee[i] = mem_oe[i];
      end else if (m_oc[i]) begin
        eo[i] = 1'b0; ee[i] = e & ~d;
      end else begin
        eo[i] = d; ee[i] = e;
      end
      ep[i] = pad_in[i] & m_conn[i] & ~m_mem;
      em[i] = pad_in[i] & m_mem;
      if (m_ana[i]) begin
        eo[i] = 1'b0; ee[i] = 1'b0; ep[i] = 1'b0; em[i] = 1'b0;
      end
    end
    return {eo, ee, ep, em};
  endfunction

  task automatic check(input string tag);
    logic [4*N-1:0] exp_v, act_v;
    #1;
    exp_v = expect_all();
    act_v = {pad_out, pad_oe, periph_in, mem_in};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {out,oe,periph,mem_in} actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic cfg_write(input logic we, input logic [2:0] addr, input logic [2*N-1:0] data);
    @(negedge clk);
    cfg_we = we; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (we) begin
      case (addr)
        3'd0: for (int i = 0; i < N; i++) m_sel[i] = m_ana[i] ? 2'b00 : data[2*i +: 2];
        3'd1: m_oc = data[N-1:0];
        3'd2: m_conn = data[N-1:0] & ~m_ana;
        3'd3: begin
          m_ana = data[N-1:0];
          m_conn = m_conn & ~data[N-1:0];
          for (int i = 0; i < N; i++) if (data[i]) m_sel[i] = 2'b00;
        end
        3'd4: m_mem = data[0];
        default: ;
      endcase
    end
  endtask

  task automatic drive_rand();
    gpio_out = N'($urandom); gpio_dir = N'($urandom);
    alt2_out = N'($urandom); alt2_oe = N'($urandom);
    alt3_out = N'($urandom); alt3_oe = N'($urandom);
    mem_out = N'($urandom); mem_oe = N'($urandom); pad_in = N'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    gpio_dir = '1; gpio_out = '1; pad_in = '1; alt2_oe = '1; alt3_oe = '1; mem_oe = '1;
    #(CLK_PERIOD * 3);
    check("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    check("R1 after reset release");

    gpio_out = 8'hA5; gpio_dir = 8'hF0;
    cfg_write(1'b1, 3'd0, 16'h5555); check("R3 gpio push-pull");
    cfg_write(1'b1, 3'd0, 16'h0000); check("R2 input mode idle");
    alt2_out = 8'h3C; alt2_oe = 8'h0F; alt3_out = 8'hC3; alt3_oe = 8'hF0;
    cfg_write(1'b1, 3'd0, 16'hAAAA); check("R4 alt2 route");
    cfg_write(1'b1, 3'd0, 16'hFFFF); check("R4 alt3 route");
    cfg_write(1'b1, 3'd0, 16'h5555);
    gpio_out = 8'h0F; gpio_dir = 8'h3C;
    cfg_write(1'b1, 3'd1, 16'h00FF); check("R5 open collector");
    cfg_write(1'b1, 3'd1, 16'h0000);
    pad_in = 8'h96;
    cfg_write(1'b1, 3'd2, 16'h003C); check("R6 input connect");
    gpio_dir = 8'hFF;
    cfg_write(1'b1, 3'd3, 16'h0081); check("R7 analog override");
    cfg_write(1'b1, 3'd0, 16'hFFFF);
    cfg_write(1'b1, 3'd2, 16'h00FF); check("R7 analog holds after writes");
    cfg_write(1'b1, 3'd3, 16'h0000); check("R8 analog pins left cleared");
    cfg_write(1'b1, 3'd4, 16'h0001); check("R9 memory handoff");
    cfg_write(1'b1, 3'd1, 16'h00FF); check("R9 type ignored in handoff");
    cfg_write(1'b1, 3'd5, 16'hFFFF); check("R10 unmapped address ignored");
    cfg_write(1'b0, 3'd4, 16'h0000); check("R10 write without strobe ignored");
    cfg_write(1'b1, 3'd4, 16'h0000); check("R9 handoff released");

    for (int k = 0; k < 600; k++) begin
      drive_rand();
      if ($urandom_range(0, 2) == 0)
        cfg_write(1'b1, 3'($urandom_range(0, 7)), 16'($urandom));
      else
        cfg_write(1'b0, 3'($urandom_range(0, 7)), 16'($urandom));
      check("R10 random mix R3 R4 R5 R6 R7 R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule